// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer

This block is a 16-bit down/up timer that serves either as a general-purpose interval timer or as a watchdog. Its count steps are taken from a slow source tick, at about 32.768 kHz. The tick reaches the block as a one-cycle enable pulse that is already synchronous to the system clock. A prescaler passes every 1st, 16th or 256th source tick to the counter. Software writes a load register, an 8-bit control register and an 8-bit clear register, and it reads the live count.

In timer mode the counter runs up or down, either free-running or periodic, and raises an interrupt each time it rolls over. Setting the watchdog bit locks the block into watchdog mode until the next reset. In that mode the counter reloads from the load register and counts down. When it reaches zero, it either pulses a reset request or raises an interrupt, as chosen by one control bit. Software must write the key value to the clear register before the counter reaches zero. With the /256 prescale and a load of 0xFFFF, the timeout is about 512 seconds.

Top module: `wdt_dual_timer`

## Requirements
- R1: After reset the count is 0, irq and rst_req are low, and the block is in timer mode with the counter disabled.
- R2: The control bits [3:2] select the prescale: 00 gives one counter step per source tick, 01 gives one step per 16 source ticks, and 10 or 11 gives one step per 256 source ticks. A control write or a refresh restarts the prescale count.
- R3: In timer mode with control bit 4 = 0, each step decrements the count. A load write sets the count at once. A step taken at 0 sets irq. It also wraps the count to 0xFFFF when control bit 6 = 0 (free-running), or reloads the count from the load register when bit 6 = 1 (periodic).
- R4: In timer mode with control bit 4 = 1, each step increments the count. A step taken at 0xFFFF sets irq. It also wraps the count to 0 when free-running, or reloads the count from the load register when periodic.
- R5: In timer mode, control bit 7 = 0 stops the counter, and ticks have no effect on the count.
- R6: A control write with bit 5 = 1 enters watchdog mode. It loads the count from the load register, and from then on the counter counts down whatever the values of bits 7 and 4.
- R7: In watchdog mode, the step that brings the count to 0 (or a step taken at 0) is the expiry. With control bit 1 = 0, expiry drives rst_req high for exactly one clock. With bit 1 = 1, expiry sets irq instead. After expiry the count holds at 0 and expiry does not repeat.
- R8: Writing 0xA5 to the clear register clears irq. In watchdog mode it also reloads the count from the load register and re-arms expiry. Any other value written to the clear register changes nothing.
- R9: Once watchdog mode has been entered, control writes are ignored until the next reset.
- R10: In watchdog mode a load write updates only the load register. The count picks up the new value at the next refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick | input | 1 | One-cycle pulse per slow source period |
| ld_we | input | 1 | Load register write strobe |
| ld_data | input | 16 | Load register write data |
| ctl_we | input | 1 | Control register write strobe |
| ctl_data | input | 8 | Control write data (bit 7 enable, 6 periodic, 5 watchdog, 4 up, 3:2 prescale, 1 expiry gives irq) |
| kick_we | input | 1 | Clear register write strobe |
| kick_data | input | 8 | Clear register write data |
| cnt_val | output | 16 | Current count |
| irq | output | 1 | Interrupt, held until cleared |
| rst_req | output | 1 | One-cycle reset request on watchdog expiry |

## Verification
Each write and each source tick that the prescaler passes takes effect at the same rising edge that samples it. The new count, irq and rst_req are therefore visible one clock after the input is driven. rst_req is high only during the clock after the expiring edge. The bench drives every input on a falling edge and releases it on the next falling edge. It then checks the outputs at that second falling edge. For the pulse it also checks one further falling edge, where rst_req must already be low again.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
// wdt_pkg: shared control-word layout for the dual-mode watchdog timer.
// Assumes the control register is 8 bits with the field order below.
package wdt_pkg;
    typedef enum logic [1:0] {
        PS_DIV1   = 2'b00,
        PS_DIV16  = 2'b01,
        PS_DIV256 = 2'b10,
        PS_DIV256B = 2'b11
    } ps_sel_e;

    typedef struct packed {
        logic    en;        // bit 7: timer-mode enable
        logic    periodic;  // bit 6: reload instead of wrap
        logic    wd;        // bit 5: enter watchdog mode
        logic    up;        // bit 4: count up in timer mode
        ps_sel_e ps;        // bits 3:2: prescale select
        logic    irq_act;   // bit 1: expiry raises irq instead of reset
        logic    spare;     // bit 0: unused
    } ctl_t;
endpackage

// File: rtl/wdt_prescaler.sv
`timescale 1ns/1ps
// wdt_prescaler: passes every 1st, 2**SHIFT_MID-th or 2**SHIFT_MAX-th
// source tick on as a counter step. Assumes src_tick is a one-cycle
// synchronous pulse; clr restarts the division.
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int SHIFT_MID = 4,
    parameter int SHIFT_MAX = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    src_tick,
    input  logic    clr,
    input  ps_sel_e sel,
    output logic    step
);
    localparam int PCW = SHIFT_MAX;
    localparam logic [PCW-1:0] MID_LAST = PCW'((1 << SHIFT_MID) - 1);
    localparam logic [PCW-1:0] MAX_LAST = PCW'((1 << SHIFT_MAX) - 1);

    logic [PCW-1:0] pcnt;
    logic [PCW-1:0] last;

    // Terminal value of the division count for the selected ratio.
    always_comb begin
        unique case (sel)
            PS_DIV1:  last = '0;
            PS_DIV16: last = MID_LAST;
            default:  last = MAX_LAST;
        endcase
    end

    assign step = src_tick && (pcnt == last);

    // Division counter advanced by source ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pcnt <= '0;
        else if (clr)
            pcnt <= '0;
        else if (src_tick)
            pcnt <= (pcnt == last) ? '0 : pcnt + 1'b1;
    end
endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
// wdt_core: load/control registers, the counter and the outputs.
// Assumes step is already divided and kick_hit is a qualified refresh.
module wdt_core
    import wdt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         ld_we,
    input  logic [W-1:0] ld_data,
    input  logic         ctl_we,
    input  ctl_t         ctl_in,
    input  logic         kick_hit,
    output logic [W-1:0] cnt_o,
    output logic         irq_o,
    output logic         rreq_o,
    output logic         locked_o,
    output logic         fired_o,
    output ctl_t         ctl_o
);
    localparam logic [W-1:0] ALL_ONES = '1;
    localparam logic [W-1:0] ONE      = W'(1);

    logic [W-1:0] load_q;
    logic [W-1:0] load_n;
    logic         ctl_ok;

    assign load_n = ld_we ? ld_data : load_q;
    assign ctl_ok = ctl_we && !locked_o;

    // Register updates: writes, refresh, counting and expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q   <= '0;
            cnt_o    <= '0;
            ctl_o    <= '0;
            locked_o <= 1'b0;
            fired_o  <= 1'b0;
            irq_o    <= 1'b0;
            rreq_o   <= 1'b0;
        end else begin
            rreq_o <= 1'b0;
            if (ld_we)
                load_q <= ld_data;
            if (ctl_ok) begin
                ctl_o <= ctl_in;
                if (ctl_in.wd)
                    locked_o <= 1'b1;
            end
            if (kick_hit) begin
                irq_o <= 1'b0;
                if (locked_o) begin
                    cnt_o   <= load_n;
                    fired_o <= 1'b0;
                end
            end else if (ld_we && !locked_o) begin
                cnt_o <= ld_data;
            end else if (ctl_ok && ctl_in.wd) begin
                cnt_o <= load_n;
            end else if (step && locked_o) begin
                if (!fired_o) begin
                    if (cnt_o <= ONE) begin
                        cnt_o   <= '0;
                        fired_o <= 1'b1;
                        if (ctl_o.irq_act)
                            irq_o  <= 1'b1;
                        else
                            rreq_o <= 1'b1;
                    end else begin
                        cnt_o <= cnt_o - 1'b1;
                    end
                end
            end else if (step && ctl_o.en) begin
                if (ctl_o.up) begin
                    if (cnt_o == ALL_ONES) begin
                        irq_o <= 1'b1;
                        cnt_o <= ctl_o.periodic ? load_q : '0;
                    end else begin
                        cnt_o <= cnt_o + 1'b1;
                    end
                end else begin
                    if (cnt_o == '0) begin
                        irq_o <= 1'b1;
                        cnt_o <= ctl_o.periodic ? load_q : ALL_ONES;
                    end else begin
                        cnt_o <= cnt_o - 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/wdt_dual_timer.sv
`timescale 1ns/1ps
// wdt_dual_timer: top level. Qualifies refresh writes against the key,
// restarts the prescaler on control writes and refreshes, and joins the
// prescaler to the counter core. Assumes src_tick is synchronous.
module wdt_dual_timer
    import wdt_pkg::*;
#(
    parameter int          W         = 16,
    parameter int          SHIFT_MID = 4,
    parameter int          SHIFT_MAX = 8,
    parameter logic [7:0]  KICK_KEY  = 8'hA5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         src_tick,
    input  logic         ld_we,
    input  logic [W-1:0] ld_data,
    input  logic         ctl_we,
    input  logic [7:0]   ctl_data,
    input  logic         kick_we,
    input  logic [7:0]   kick_data,
    output logic [W-1:0] cnt_val,
    output logic         irq,
    output logic         rst_req
);
    logic kick_hit;
    logic wd_locked;
    logic wd_fired;
    logic pre_clr;
    logic step;
    ctl_t ctl_q;

    assign kick_hit = kick_we && (kick_data == KICK_KEY);
    assign pre_clr  = kick_hit || (ctl_we && !wd_locked);

    wdt_prescaler #(
        .SHIFT_MID (SHIFT_MID),
        .SHIFT_MAX (SHIFT_MAX)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .clr      (pre_clr),
        .sel      (ctl_q.ps),
        .step     (step)
    );

    wdt_core #(
        .W (W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .ld_we    (ld_we),
        .ld_data  (ld_data),
        .ctl_we   (ctl_we),
        .ctl_in   (ctl_t'(ctl_data)),
        .kick_hit (kick_hit),
        .cnt_o    (cnt_val),
        .irq_o    (irq),
        .rreq_o   (rst_req),
        .locked_o (wd_locked),
        .fired_o  (wd_fired),
        .ctl_o    (ctl_q)
    );
endmodule

// File: rtl/wdt_checker.sv
`timescale 1ns/1ps
// wdt_checker: temporal properties of the dual-mode watchdog timer,
// attached to every instance of the top module by bind.
module wdt_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         kick_hit,
    input logic         locked,
    input logic         fired,
    input logic         act_irq,
    input logic [W-1:0] cnt_val,
    input logic         irq,
    input logic         rst_req
);
    // Watchdog mode cannot be left without reset.
    assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // Reset request lasts exactly one cycle.
    assert_rreq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // Reset request only from watchdog mode with the reset action chosen.
    assert_rreq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (locked && !act_irq));

    // Count holds at zero after expiry until refreshed.
    assert_hold_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fired && !kick_hit) |=> (cnt_val == '0));

    // A refresh withdraws the interrupt.
    assert_kick_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        kick_hit |=> !irq);

    // In watchdog mode the count never rises without a refresh.
    assert_wd_down_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !kick_hit) |=> (cnt_val <= $past(cnt_val)));
endmodule

bind wdt_dual_timer wdt_checker #(.W(W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .kick_hit (kick_hit),
    .locked   (wd_locked),
    .fired    (wd_fired),
    .act_irq  (ctl_q.irq_act),
    .cnt_val  (cnt_val),
    .irq      (irq),
    .rst_req  (rst_req)
);

// File: tb/wdt_dual_timer_tb.sv
`timescale 1ns/1ps
// Bench for wdt_dual_timer: table-driven timer-mode sequence, then
// directed watchdog, lock and refresh tests.
module wdt_dual_timer_tb_top;
    localparam logic [1:0] OP_LOAD = 2'd0;
    localparam logic [1:0] OP_CTL  = 2'd1;
    localparam logic [1:0] OP_KICK = 2'd2;
    localparam logic [1:0] OP_TICK = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] arg;
        logic [15:0] ecnt;
        logic        eirq;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t TBL [NV] = '{
        '{OP_LOAD, 16'h0005, 16'h0005, 1'b0, 4'd3},  // R3 load sets count
        '{OP_CTL,  16'h0080, 16'h0005, 1'b0, 4'd3},  // enable, down, /1
        '{OP_TICK, 16'd3,    16'h0002, 1'b0, 4'd3},
        '{OP_TICK, 16'd2,    16'h0000, 1'b0, 4'd3},
        '{OP_TICK, 16'd1,    16'hFFFF, 1'b1, 4'd3},  // R3 free-running wrap
        '{OP_KICK, 16'h0012, 16'hFFFF, 1'b1, 4'd8},  // R8 wrong key ignored
        '{OP_KICK, 16'h00A5, 16'hFFFF, 1'b0, 4'd8},  // R8 key clears irq
        '{OP_CTL,  16'h0000, 16'hFFFF, 1'b0, 4'd5},
        '{OP_TICK, 16'd4,    16'hFFFF, 1'b0, 4'd5},  // R5 disabled holds
        '{OP_CTL,  16'h00C0, 16'hFFFF, 1'b0, 4'd3},
        '{OP_LOAD, 16'h0002, 16'h0002, 1'b0, 4'd3},
        '{OP_TICK, 16'd3,    16'h0002, 1'b1, 4'd3},  // R3 periodic reload
        '{OP_KICK, 16'h00A5, 16'h0002, 1'b0, 4'd8},
        '{OP_CTL,  16'h0090, 16'h0002, 1'b0, 4'd4},
        '{OP_LOAD, 16'hFFFE, 16'hFFFE, 1'b0, 4'd4},
        '{OP_TICK, 16'd2,    16'h0000, 1'b1, 4'd4},  // R4 up wrap
        '{OP_KICK, 16'h00A5, 16'h0000, 1'b0, 4'd8},
        '{OP_CTL,  16'h00D4, 16'h0000, 1'b0, 4'd2},  // up periodic /16
        '{OP_LOAD, 16'h0010, 16'h0010, 1'b0, 4'd2},
        '{OP_TICK, 16'd15,   16'h0010, 1'b0, 4'd2},  // R2 no step yet
        '{OP_TICK, 16'd1,    16'h0011, 1'b0, 4'd2},  // R2 16th tick steps
        '{OP_CTL,  16'h0088, 16'h0011, 1'b0, 4'd2},  // down /256
        '{OP_TICK, 16'd255,  16'h0011, 1'b0, 4'd2},
        '{OP_TICK, 16'd1,    16'h0010, 1'b0, 4'd2}   // R2 256th tick steps
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_tick = 1'b0;
    logic        ld_we = 1'b0;
    logic [15:0] ld_data = '0;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_data = '0;
    logic        kick_we = 1'b0;
    logic [7:0]  kick_data = '0;
    logic [15:0] cnt_val;
    logic        irq;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdt_dual_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_tick  (src_tick),
        .ld_we     (ld_we),
        .ld_data   (ld_data),
        .ctl_we    (ctl_we),
        .ctl_data  (ctl_data),
        .kick_we   (kick_we),
        .kick_data (kick_data),
        .cnt_val   (cnt_val),
        .irq       (irq),
        .rst_req   (rst_req)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_op(input logic [1:0] op, input logic [15:0] arg);
        if (op == OP_TICK) begin
            for (int i = 0; i < int'(arg); i++) begin
                @(negedge clk);
                src_tick = 1'b1;
            end
            @(negedge clk);
            src_tick = 1'b0;
        end else begin
            @(negedge clk);
            ld_we = (op == OP_LOAD);
            ctl_we = (op == OP_CTL);
            kick_we = (op == OP_KICK);
            ld_data = arg;
            ctl_data = arg[7:0];
            kick_data = arg[7:0];
            @(negedge clk);
            ld_we = 1'b0;
            ctl_we = 1'b0;
            kick_we = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog: got=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 count", cnt_val, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 rst_req", {15'd0, rst_req}, 16'd0);

        // Timer-mode table (R2 R3 R4 R5 R8)
        for (int v = 0; v < NV; v++) begin
            do_op(TBL[v].op, TBL[v].arg);
            chk($sformatf("R%0d vec%0d count", TBL[v].rq, v), cnt_val, TBL[v].ecnt);
            chk($sformatf("R%0d vec%0d irq", TBL[v].rq, v), {15'd0, irq}, {15'd0, TBL[v].eirq});
        end

        // Watchdog with reset action
        do_reset();
        do_op(OP_LOAD, 16'd3);
        do_op(OP_CTL, 16'h0020);
        chk("R6 entry loads count", cnt_val, 16'd3);
        do_op(OP_TICK, 16'd2);
        chk("R6 counts down with enable clear", cnt_val, 16'd1);
        do_op(OP_TICK, 16'd1);
        chk("R7 expiry count", cnt_val, 16'd0);
        chk("R7 rst_req pulse", {15'd0, rst_req}, 16'd1);
        chk("R7 no irq on reset action", {15'd0, irq}, 16'd0);
        @(negedge clk);
        chk("R7 rst_req one cycle", {15'd0, rst_req}, 16'd0);
        do_op(OP_TICK, 16'd3);
        chk("R7 hold at zero", cnt_val, 16'd0);
        chk("R7 no repeat", {15'd0, rst_req}, 16'd0);
        do_op(OP_KICK, 16'h00A5);
        chk("R8 refresh reloads", cnt_val, 16'd3);
        do_op(OP_CTL, 16'h0090);
        do_op(OP_TICK, 16'd1);
        chk("R9 control write ignored", cnt_val, 16'd2);
        do_op(OP_LOAD, 16'd7);
        chk("R10 load leaves count", cnt_val, 16'd2);
        do_op(OP_KICK, 16'h005A);
        chk("R8 wrong key ignored", cnt_val, 16'd2);
        do_op(OP_KICK, 16'h00A5);
        chk("R10 refresh takes new load", cnt_val, 16'd7);
        do_op(OP_TICK, 16'd1);
        chk("R9 still watchdog", cnt_val, 16'd6);

        // Watchdog with interrupt action
        do_reset();
        do_op(OP_LOAD, 16'd2);
        do_op(OP_CTL, 16'h0022);
        do_op(OP_TICK, 16'd2);
        chk("R7 irq action count", cnt_val, 16'd0);
        chk("R7 irq action irq", {15'd0, irq}, 16'd1);
        chk("R7 irq action no rst_req", {15'd0, rst_req}, 16'd0);
        do_op(OP_KICK, 16'h00A5);
        chk("R8 refresh clears irq", {15'd0, irq}, 16'd0);
        chk("R8 refresh reload", cnt_val, 16'd2);

        // Watchdog with /16 prescale
        do_reset();
        do_op(OP_LOAD, 16'd1);
        do_op(OP_CTL, 16'h0024);
        do_op(OP_TICK, 16'd15);
        chk("R2 watchdog /16 waits", cnt_val, 16'd1);
        do_op(OP_TICK, 16'd1);
        chk("R2 watchdog /16 expiry", cnt_val, 16'd0);
        chk("R7 watchdog /16 rst_req", {15'd0, rst_req}, 16'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule